// File: doc/BRIEF.md
# MMU Translation Context Selector

This block decides, for each instruction fetch or data access, how the address will be translated. It takes one packed per-thread control word, three flags that classify the access's address space identifier, a secondary context value, the access type and the virtual address. From these it reports one of three outcomes. The access may bypass translation, in which case the physical address is the virtual address cut to the implemented width. It may be a real-address translation under context 0. Or it may be a virtual translation under the primary, secondary or nucleus context. It also reports the partition identifier that the lookup must use.

The block accepts one request per cycle through a valid/ready pair. It presents the result from a register one cycle after acceptance and holds it until the consumer takes it. The TLB array, fault ordering and address range checks are outside this block.

Control word fields used: bit 0 hyperprivileged, bit 1 RED state, bit 4 instruction-translation enable, bit 5 data-translation enable, bits 15:8 partition, bits 18:16 trap level, bits 47:32 primary context. All other bits have no effect.

Top module: `mmu_ctx_sel`

## Requirements
- R1: While reset is asserted and after release with no request, rsp_valid is 0 and req_ready is 1.
- R2: Every response carries rsp_pid equal to bits 15:8 of the accepted control word. Bits 2, 3 and 63 of the control word change no output.
- R3: For an instruction fetch (req_ifetch=1) with bit 0 or bit 1 set, the response has rsp_bypass=1, rsp_real=0, rsp_ctx=0 and rsp_kind=3 (none). rsp_paddr equals req_vaddr with every bit at or above PA_W cleared.
- R4: For an instruction fetch that does not bypass, a clear bit 4 gives rsp_real=1, rsp_ctx=0, rsp_kind=3. Otherwise a trap level above 0 gives the nucleus (rsp_kind=2, rsp_ctx=0), and a trap level of 0 gives the primary (rsp_kind=0, rsp_ctx=bits 47:32). The three address-space flags are ignored for fetches.
- R5: For a data access (req_ifetch=0) with bit 0 or bit 1 set, the response is a bypass with the same encoding and rsp_paddr rule as R3.
- R6: For a non-bypass data access with bit 5 clear or req_asi_real=1, the response is rsp_real=1, rsp_ctx=0, rsp_kind=3. This takes priority over the nucleus and secondary choices.
- R7: For a non-bypass, non-real data access, a trap level above 0 or req_asi_nucleus=1 selects the nucleus (rsp_kind=2, rsp_ctx=0). This takes priority over the secondary choice.
- R8: Otherwise req_asi_secondary=1 selects rsp_kind=1 with rsp_ctx=req_sec_ctx, and any other data access selects rsp_kind=0 with rsp_ctx=bits 47:32.
- R9: A request is accepted when req_valid and req_ready are both 1. Its response is valid in the next cycle. req_ready equals (not rsp_valid) or rsp_ready. A response stays unchanged while rsp_valid=1 and rsp_ready=0.
- R10: When a response is consumed in the same cycle a new request is accepted, rsp_valid stays 1 and the next cycle shows the new request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ifetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_ctl | input | CTL_W | Packed per-thread control word |
| req_sec_ctx | input | CTX_W | Secondary context value |
| req_asi_nucleus | input | 1 | Address space is a nucleus space |
| req_asi_secondary | input | 1 | Address space is a secondary space |
| req_asi_real | input | 1 | Address space is a real-address space |
| req_vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_bypass | output | 1 | Translation bypassed |
| rsp_real | output | 1 | Real-address translation |
| rsp_kind | output | 2 | 0 primary, 1 secondary, 2 nucleus, 3 none |
| rsp_ctx | output | CTX_W | Context for the lookup |
| rsp_pid | output | PID_W | Partition for the lookup |
| rsp_paddr | output | VA_W | Virtual address cut to PA_W bits |

## Verification
Two events can share one clock edge: draining the held response and capturing a new request. The bench first stalls the consumer with one result held. It then presents a second request of a different context kind while still stalling, and confirms that the held result does not move. Next it raises rsp_ready while the second request is still offered. In the following cycle it judges that rsp_valid never dropped and that the outputs now carry the second request's kind and context.

// File: rtl/ctx_sel_pkg.sv
package ctx_sel_pkg;
  localparam int HP_BIT   = 0;
  localparam int RED_BIT  = 1;
  localparam int IEN_BIT  = 4;
  localparam int DEN_BIT  = 5;
  localparam int PID_LSB  = 8;
  localparam int TL_LSB   = 16;
  localparam int TL_W     = 3;
  localparam int PCTX_LSB = 32;

  typedef enum logic [1:0] {
    KIND_PRIMARY   = 2'd0,
    KIND_SECONDARY = 2'd1,
    KIND_NUCLEUS   = 2'd2,
    KIND_NONE      = 2'd3
  } ctx_kind_e;

  typedef struct packed {
    logic      bypass;
    logic      real_xl;
    ctx_kind_e kind;
  } ctx_dec_t;
endpackage

// File: rtl/ctx_word_dec.sv
module ctx_word_dec
  import ctx_sel_pkg::*;
#(
  parameter int CTL_W = 64,
  parameter int CTX_W = 16,
  parameter int PID_W = 8
) (
  input  logic [CTL_W-1:0] ctl_i,
  output logic             hp_o,
  output logic             red_o,
  output logic             ien_o,
  output logic             den_o,
  output logic [TL_W-1:0]  tl_o,
  output logic [CTX_W-1:0] pctx_o,
  output logic [PID_W-1:0] pid_o
);
  logic ctl_unused;

  assign hp_o   = ctl_i[HP_BIT];
  assign red_o  = ctl_i[RED_BIT];
  assign ien_o  = ctl_i[IEN_BIT];
  assign den_o  = ctl_i[DEN_BIT];
  assign tl_o   = ctl_i[TL_LSB +: TL_W];
  assign pctx_o = ctl_i[PCTX_LSB +: CTX_W];
  assign pid_o  = ctl_i[PID_LSB +: PID_W];

  assign ctl_unused = ^ctl_i;
endmodule

// File: rtl/ctx_rule.sv
module ctx_rule
  import ctx_sel_pkg::*;
(
  input  logic            ifetch_i,
  input  logic            hp_i,
  input  logic            red_i,
  input  logic            ien_i,
  input  logic            den_i,
  input  logic [TL_W-1:0] tl_i,
  input  logic            asi_nuc_i,
  input  logic            asi_sec_i,
  input  logic            asi_real_i,
  output ctx_dec_t        dec_o
);
  logic tl_nz;

  assign tl_nz = |tl_i;

  always_comb begin
    dec_o.bypass  = 1'b0;
    dec_o.real_xl = 1'b0;
    dec_o.kind    = KIND_PRIMARY;
    if (hp_i || red_i) begin
      dec_o.bypass = 1'b1;
      dec_o.kind   = KIND_NONE;
    end else if (ifetch_i) begin
      if (!ien_i) begin
        dec_o.real_xl = 1'b1;
        dec_o.kind    = KIND_NONE;
      end else if (tl_nz) begin
        dec_o.kind = KIND_NUCLEUS;
      end
    end else begin
      if (!den_i || asi_real_i) begin
        dec_o.real_xl = 1'b1;
        dec_o.kind    = KIND_NONE;
      end else if (tl_nz || asi_nuc_i) begin
        dec_o.kind = KIND_NUCLEUS;
      end else if (asi_sec_i) begin
        dec_o.kind = KIND_SECONDARY;
      end
    end
  end
endmodule

// File: rtl/ctx_out_reg.sv
module ctx_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         load_en;

  assign in_ready = !vld_q || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (load_en)        vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/mmu_ctx_sel.sv
module mmu_ctx_sel
  import ctx_sel_pkg::*;
#(
  parameter int CTL_W = 64,
  parameter int CTX_W = 16,
  parameter int PID_W = 8,
  parameter int VA_W  = 64,
  parameter int PA_W  = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_ifetch,
  input  logic [CTL_W-1:0] req_ctl,
  input  logic [CTX_W-1:0] req_sec_ctx,
  input  logic             req_asi_nucleus,
  input  logic             req_asi_secondary,
  input  logic             req_asi_real,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_bypass,
  output logic             rsp_real,
  output logic [1:0]       rsp_kind,
  output logic [CTX_W-1:0] rsp_ctx,
  output logic [PID_W-1:0] rsp_pid,
  output logic [VA_W-1:0]  rsp_paddr
);
  localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};
  localparam int PAY_W = $bits(ctx_dec_t) + CTX_W + PID_W + VA_W;

  logic             hp, red, ien, den;
  logic [TL_W-1:0]  tl;
  logic [CTX_W-1:0] pctx, ctx_sel;
  logic [PID_W-1:0] pid;
  ctx_dec_t         dec, dec_q;
  logic [PAY_W-1:0] pay_d, pay_q;

  ctx_word_dec #(.CTL_W(CTL_W), .CTX_W(CTX_W), .PID_W(PID_W)) u_dec (
    .ctl_i (req_ctl),
    .hp_o  (hp),
    .red_o (red),
    .ien_o (ien),
    .den_o (den),
    .tl_o  (tl),
    .pctx_o(pctx),
    .pid_o (pid)
  );

  ctx_rule u_rule (
    .ifetch_i  (req_ifetch),
    .hp_i      (hp),
    .red_i     (red),
    .ien_i     (ien),
    .den_i     (den),
    .tl_i      (tl),
    .asi_nuc_i (req_asi_nucleus),
    .asi_sec_i (req_asi_secondary),
    .asi_real_i(req_asi_real),
    .dec_o     (dec)
  );

  always_comb begin
    case (dec.kind)
      KIND_PRIMARY:   ctx_sel = pctx;
      KIND_SECONDARY: ctx_sel = req_sec_ctx;
      default:        ctx_sel = '0;
    endcase
  end

  assign pay_d = {dec, ctx_sel, pid, req_vaddr & PA_MASK};

  ctx_out_reg #(.W(PAY_W)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_data  (pay_d),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (pay_q)
  );

  assign {dec_q, rsp_ctx, rsp_pid, rsp_paddr} = pay_q;
  assign rsp_bypass = dec_q.bypass;
  assign rsp_real   = dec_q.real_xl;
  assign rsp_kind   = dec_q.kind;
endmodule

// File: rtl/ctx_sel_chk.sv
module ctx_sel_chk #(
  parameter int CTL_W = 64,
  parameter int CTX_W = 16,
  parameter int PID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CTL_W-1:0] req_ctl,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_bypass,
  input logic             rsp_real,
  input logic [1:0]       rsp_kind,
  input logic [CTX_W-1:0] rsp_ctx,
  input logic [PID_W-1:0] rsp_pid
);
  // R9
  accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R9
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ctx) && $stable(rsp_kind)
                                   && $stable(rsp_pid) && $stable(rsp_bypass)));
  // R10
  overlap_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && req_valid) |=> rsp_valid);
  // R2
  pid_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_pid == $past(req_ctl[15:8])));
  // R3
  bypass_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_bypass && rsp_real));
  // R6
  real_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_real || rsp_bypass)) |-> (rsp_ctx == '0 && rsp_kind == 2'd3));
endmodule

bind mmu_ctx_sel ctx_sel_chk #(.CTL_W(CTL_W), .CTX_W(CTX_W), .PID_W(PID_W)) u_chk (.*);

// File: tb/mmu_ctx_sel_tb.sv
module mmu_ctx_sel_tb;
  localparam int CTL_W = 64, CTX_W = 16, PID_W = 8, VA_W = 64, PA_W = 40;
  localparam int NV = 15;
  localparam logic [CTX_W-1:0] PCTX = 16'h1234;
  localparam logic [CTX_W-1:0] SCTX = 16'hABCD;
  localparam logic [PID_W-1:0] PID  = 8'h5A;
  localparam logic [VA_W-1:0]  VA   = 64'hFFFF_FF12_3456_789A;
  localparam logic [VA_W-1:0]  PA   = 64'h0000_0012_3456_789A;
  // ifetch hp red ien den tl nuc sec rasi | byp real kind
  localparam logic [14:0] VECS [NV] = '{
    15'b1_1_0_1_1_000_0_0_0_1_0_11,
    15'b1_0_1_0_0_000_0_0_0_1_0_11,
    15'b1_0_0_0_1_000_0_0_0_0_1_11,
    15'b1_0_0_1_0_000_1_1_1_0_0_00,
    15'b1_0_0_1_0_010_0_0_0_0_0_10,
    15'b0_1_0_1_0_000_0_1_0_1_0_11,
    15'b0_0_1_1_1_000_0_0_0_1_0_11,
    15'b0_0_0_1_0_000_0_0_0_0_1_11,
    15'b0_0_0_1_1_000_0_0_1_0_1_11,
    15'b0_0_0_0_1_001_0_0_0_0_0_10,
    15'b0_0_0_0_1_000_1_0_0_0_0_10,
    15'b0_0_0_0_1_000_0_1_0_0_0_01,
    15'b0_0_0_0_1_000_0_0_0_0_0_00,
    15'b0_0_0_0_1_111_0_1_0_0_0_10,
    15'b0_0_0_0_1_000_1_0_1_0_1_11
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ifetch = 1'b0, rsp_ready = 1'b1;
  logic req_asi_nucleus = 1'b0, req_asi_secondary = 1'b0, req_asi_real = 1'b0;
  logic [CTL_W-1:0] req_ctl = '0;
  logic [CTX_W-1:0] req_sec_ctx = SCTX;
  logic [VA_W-1:0]  req_vaddr = VA;
  logic req_ready, rsp_valid, rsp_bypass, rsp_real;
  logic [1:0] rsp_kind;
  logic [CTX_W-1:0] rsp_ctx;
  logic [PID_W-1:0] rsp_pid;
  logic [VA_W-1:0]  rsp_paddr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mmu_ctx_sel u_dut (.*);

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [14:0] v);
    req_ifetch        = v[14];
    req_ctl           = '0;
    req_ctl[0]        = v[13];
    req_ctl[1]        = v[12];
    req_ctl[2]        = 1'b1;
    req_ctl[3]        = 1'b1;
    req_ctl[4]        = v[11];
    req_ctl[5]        = v[10];
    req_ctl[15:8]     = PID;
    req_ctl[18:16]    = v[9:7];
    req_ctl[47:32]    = PCTX;
    req_ctl[63]       = 1'b1;
    req_asi_nucleus   = v[6];
    req_asi_secondary = v[5];
    req_asi_real      = v[4];
  endtask

  function automatic logic [CTX_W-1:0] exp_ctx(input logic [1:0] k);
    return (k == 2'd0) ? PCTX : (k == 2'd1) ? SCTX : '0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R1", "valid in reset", rsp_valid, 0);
    check("R1", "ready in reset", req_ready, 1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid idle", rsp_valid, 0);
    check("R1", "ready idle", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [14:0] v = VECS[i];
      if (v[3])                    tag = v[14] ? "R3" : "R5";
      else if (v[14])              tag = "R4";
      else if (v[2])               tag = "R6";
      else if (v[1:0] == 2'd2)     tag = "R7";
      else                         tag = "R8";
      drive(v);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R9", "rsp_valid", rsp_valid, 1);
      check(tag, "bypass", rsp_bypass, v[3]);
      check(tag, "real", rsp_real, v[2]);
      check(tag, "kind", rsp_kind, v[1:0]);
      check(tag, "ctx", rsp_ctx, exp_ctx(v[1:0]));
      check("R2", "pid", rsp_pid, PID);
      if (v[3]) check(tag, "paddr", rsp_paddr, PA);
      @(negedge clk);
      check("R9", "drained", rsp_valid, 0);
    end

    // R9 stall then R10 overlap
    rsp_ready = 1'b0;
    drive(VECS[12]);
    req_valid = 1'b1;
    @(negedge clk);
    check("R9", "stall valid", rsp_valid, 1);
    check("R9", "stall ready", req_ready, 0);
    drive(VECS[11]);
    @(negedge clk);
    check("R9", "held kind", rsp_kind, 0);
    check("R9", "held ctx", rsp_ctx, PCTX);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "overlap valid", rsp_valid, 1);
    check("R10", "overlap kind", rsp_kind, 1);
    check("R10", "overlap ctx", rsp_ctx, SCTX);
    @(negedge clk);
    check("R9", "final drain", rsp_valid, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule